// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block gives a small processor core access to off-chip memory over a narrow shared bus. The core sees a simple request port. It presents a 16-bit byte address, write data, and a read or write request while `ready` is high. It then receives a one-cycle `rsp_done` pulse, with read data alongside it on reads.

On the outside, the low address byte and the data byte take turns on one 8-bit bus. In the first phase the controller raises an active-high latch strobe and puts the low address byte on the bus, so an external transparent latch can hold it. The upper address byte leaves on eight dedicated lines. An active-low read or write strobe then carries the data transfer. The bus is used only when the enable input is set and the address lies above the on-chip RAM region (the first 4 KB). Requests below that region, and all requests while the block is disabled, are ignored at the pins.

Every access has a fixed length. There is one latch cycle, one turnaround cycle, one strobe cycle and one release cycle, and the controller takes the next request only after the release cycle.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: After reset the pins are idle: `ext_ale`=0, `ext_rd_n`=1, `ext_wr_n`=1, `ext_ad_oe`=0, `rsp_done`=0, and `ready`=1 once `xmem_en`=1.
- R2: While `xmem_en`=0 every request is ignored: no latch pulse, no strobe, no bus drive and no `rsp_done`.
- R3: A request whose address is below 0x1000 is ignored at the pins and gives no `rsp_done`. Addresses 0x1000 to 0xFFFF are carried out on the bus.
- R4: In the cycle after a request is accepted, `ext_ale`=1 for exactly one cycle, `ext_ad_oe`=1 and `ext_ad_out` holds address bits 7..0. `ext_ahi` holds address bits 15..8 from that cycle through the `rsp_done` cycle.
- R5: The second cycle of an access is a turnaround: `ext_ale`=0 and both strobes are high.
- R6: On a read, `ext_rd_n`=0 only in the third cycle and `ext_ad_oe`=0 from the second cycle to the end. `rsp_rdata` equals `ext_ad_in` as sampled at the end of the strobe cycle.
- R7: On a write, `ext_wr_n`=0 only in the third cycle. `ext_ad_oe`=1 and `ext_ad_out` holds the write data in the second, third and fourth cycles. The two strobes are never low together.
- R8: `rsp_done`=1 for exactly one cycle, in the fourth cycle. `ready`=0 from the first cycle through the fourth, and `ready`=1 again in the cycle after.
- R9: A read and a write requested in the same cycle produce one read access and no write strobe.
- R10: A request raised while `ready`=0 is ignored; it starts no second access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xmem_en | input | 1 | External interface enable |
| req_rd | input | 1 | Read request, sampled when `ready`=1 |
| req_wr | input | 1 | Write request, sampled when `ready`=1 |
| req_addr | input | 16 | Byte address of the request |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Read data, valid with `rsp_done` |
| rsp_done | output | 1 | One-cycle completion pulse |
| ready | output | 1 | Controller idle and enabled |
| ext_ale | output | 1 | Address latch enable, active high |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_ad_out | output | 8 | Shared address/data bus, output path |
| ext_ad_oe | output | 1 | Output enable for the shared bus |
| ext_ad_in | input | 8 | Shared address/data bus, input path |
| ext_ahi | output | 8 | Dedicated upper address lines |

## Verification
The bench also covers a second request that arrives while an access is already in progress. Two collisions matter. A read and a write requested in the same cycle must resolve to a single read. A new write request raised during the turnaround of a read must not start a second address phase. The bench raises both request lines together on the same edge, and it also pulses a write request in the cycle after a latch pulse. It judges the result by counting latch pulses and strobes, and it checks that the only transfer is the expected read, at the address reassembled from the latch model and the upper lines.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  // Access phases, in the order they occur on the pins.
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_TURN = 3'd2,
    PH_STRB = 3'd3,
    PH_HOLD = 3'd4
  } phase_e;

endpackage

// File: rtl/xmem_req_filter.sv
module xmem_req_filter #(
  parameter int AW          = 16,
  parameter int LOCAL_BYTES = 4096
) (
  input  logic          enable,
  input  logic          idle,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  output logic          take,
  output logic          take_rd
);

  localparam logic [AW-1:0] LIMIT = AW'(LOCAL_BYTES);

  logic above_local;

  always_comb begin
    above_local = (addr >= LIMIT);
    take        = enable & idle & (rd | wr) & above_local;
    // A read wins when both request lines are high.
    take_rd     = rd;
  end

endmodule

// File: rtl/xmem_phase_seq.sv
module xmem_phase_seq
  import xmem_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   take,
  output phase_e phase
);

  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (take) phase_d = PH_ADDR;
      PH_ADDR: phase_d = PH_TURN;
      PH_TURN: phase_d = PH_STRB;
      PH_STRB: phase_d = PH_HOLD;
      PH_HOLD: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

endmodule

// File: rtl/xmem_pin_drive.sv
module xmem_pin_drive
  import xmem_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             take_rd,
  input  logic [AW-1:0]    addr_in,
  input  logic [DW-1:0]    wdata_in,
  input  phase_e           phase,
  input  logic [DW-1:0]    ad_in,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  output logic [AW-DW-1:0] ahi,
  output logic [DW-1:0]    rdata,
  output logic             done
);

  localparam int HW = AW - DW;

  logic          op_rd_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          cap_en;

  // Request capture, loaded on the accepting edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_rd_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take) begin
      op_rd_q <= take_rd;
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
    end
  end

  // Read data is taken at the edge that ends the strobe cycle.
  assign cap_en = (phase == PH_STRB) && op_rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= ad_in;
  end

  always_comb begin
    ale    = 1'b0;
    rd_n   = 1'b1;
    wr_n   = 1'b1;
    ad_oe  = 1'b0;
    ad_out = '0;
    done   = 1'b0;
    unique case (phase)
      PH_ADDR: begin
        ale    = 1'b1;
        ad_oe  = 1'b1;
        ad_out = addr_q[DW-1:0];
      end
      PH_TURN: begin
        ad_oe  = ~op_rd_q;
        ad_out = op_rd_q ? '0 : wdata_q;
      end
      PH_STRB: begin
        ad_oe  = ~op_rd_q;
        ad_out = op_rd_q ? '0 : wdata_q;
        rd_n   = ~op_rd_q;
        wr_n   = op_rd_q;
      end
      PH_HOLD: begin
        ad_oe  = ~op_rd_q;
        ad_out = op_rd_q ? '0 : wdata_q;
        done   = 1'b1;
      end
      default: ;
    endcase
  end

  assign ahi   = addr_q[AW-1:AW-HW];
  assign rdata = rdata_q;

endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
  import xmem_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 8,
  parameter int LOCAL_BYTES = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xmem_en,
  input  logic             req_rd,
  input  logic             req_wr,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic [DW-1:0]    rsp_rdata,
  output logic             rsp_done,
  output logic             ready,
  output logic             ext_ale,
  output logic             ext_rd_n,
  output logic             ext_wr_n,
  output logic [DW-1:0]    ext_ad_out,
  output logic             ext_ad_oe,
  input  logic [DW-1:0]    ext_ad_in,
  output logic [AW-DW-1:0] ext_ahi
);

  phase_e phase;
  logic   idle;
  logic   take;
  logic   take_rd;

  assign idle  = (phase == PH_IDLE);
  assign ready = idle & xmem_en;

  xmem_req_filter #(
    .AW          (AW),
    .LOCAL_BYTES (LOCAL_BYTES)
  ) u_filter (
    .enable  (xmem_en),
    .idle    (idle),
    .rd      (req_rd),
    .wr      (req_wr),
    .addr    (req_addr),
    .take    (take),
    .take_rd (take_rd)
  );

  xmem_phase_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .phase (phase)
  );

  xmem_pin_drive #(
    .AW (AW),
    .DW (DW)
  ) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .take_rd  (take_rd),
    .addr_in  (req_addr),
    .wdata_in (req_wdata),
    .phase    (phase),
    .ad_in    (ext_ad_in),
    .ale      (ext_ale),
    .rd_n     (ext_rd_n),
    .wr_n     (ext_wr_n),
    .ad_out   (ext_ad_out),
    .ad_oe    (ext_ad_oe),
    .ahi      (ext_ahi),
    .rdata    (rsp_rdata),
    .done     (rsp_done)
  );

endmodule

// File: rtl/xmem_bus_ctrl_chk.sv
module xmem_bus_ctrl_chk #(
  parameter int AW          = 16,
  parameter int DW          = 8,
  parameter int LOCAL_BYTES = 4096
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xmem_en,
  input logic             rsp_done,
  input logic             ready,
  input logic             ext_ale,
  input logic             ext_rd_n,
  input logic             ext_wr_n,
  input logic [DW-1:0]    ext_ad_out,
  input logic             ext_ad_oe,
  input logic [AW-DW-1:0] ext_ahi
);

  assert_ale_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ale |=> !ext_ale);

  assert_ahi_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n || !ext_wr_n || rsp_done) |-> $stable(ext_ahi));

  assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ale |=> (ext_rd_n && ext_wr_n));

  assert_strobe_after_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n || !ext_wr_n) |-> $past(ext_ale, 2));

  assert_read_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_rd_n |-> !ext_ad_oe);

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_busy_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !ready);

  assert_enable_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_ale) |-> $past(xmem_en));

  assert_ext_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ale |-> (32'({ext_ahi, ext_ad_out}) >= LOCAL_BYTES));

endmodule

bind xmem_bus_ctrl xmem_bus_ctrl_chk #(
  .AW          (AW),
  .DW          (DW),
  .LOCAL_BYTES (LOCAL_BYTES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xmem_en    (xmem_en),
  .rsp_done   (rsp_done),
  .ready      (ready),
  .ext_ale    (ext_ale),
  .ext_rd_n   (ext_rd_n),
  .ext_wr_n   (ext_wr_n),
  .ext_ad_out (ext_ad_out),
  .ext_ad_oe  (ext_ad_oe),
  .ext_ahi    (ext_ahi)
);

// File: tb/xmem_bus_ctrl_test.sv
module xmem_ext_latch_model (
  input  logic       clk,
  input  logic       le,
  input  logic [7:0] d,
  output logic [7:0] q
);
  always @(posedge clk) if (le) q <= d;
endmodule

module xmem_bus_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        xmem_en;
  logic        req_rd;
  logic        req_wr;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic [7:0]  rsp_rdata;
  logic        rsp_done;
  logic        ready;
  logic        ext_ale;
  logic        ext_rd_n;
  logic        ext_wr_n;
  logic [7:0]  ext_ad_out;
  logic        ext_ad_oe;
  logic [7:0]  ext_ad_in;
  logic [7:0]  ext_ahi;
  logic [7:0]  lat_q;

  always #2 clk = ~clk;

  xmem_bus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .xmem_en(xmem_en),
    .req_rd(req_rd), .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .ready(ready),
    .ext_ale(ext_ale), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
    .ext_ad_out(ext_ad_out), .ext_ad_oe(ext_ad_oe), .ext_ad_in(ext_ad_in),
    .ext_ahi(ext_ahi)
  );

  xmem_ext_latch_model u_latch (.clk(clk), .le(ext_ale), .d(ext_ad_out), .q(lat_q));

  function automatic logic [7:0] mem_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hC3;
  endfunction

  assign ext_ad_in = mem_val({ext_ahi, lat_q});

  typedef struct {
    logic        rd;
    logic [15:0] a;
    logic [7:0]  d;
  } item_t;

  item_t exp_q[$];
  int n_vec = 0;
  int n_bad = 0;
  int ale_cnt = 0;
  int done_cnt = 0;
  logic ale_prev = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: compares bus transfers and completions against the queue.
  always @(negedge clk) begin
    if (rst_n) begin
      if (ext_ale && !ale_prev) ale_cnt++;
      ale_prev <= ext_ale;
      if (!ext_rd_n || !ext_wr_n) begin
        if (exp_q.size() == 0) chk("R2/R3 unexpected strobe", 1, 0);
        else begin
          chk("R4 latched address at strobe", {ext_ahi, lat_q}, exp_q[0].a);
          chk("R9 strobe kind", {31'd0, ext_rd_n}, {31'd0, !exp_q[0].rd});
          if (!exp_q[0].rd) chk("R7 write data on bus", {ext_ad_oe, ext_ad_out}, {1'b1, exp_q[0].d});
          else              chk("R6 bus released on read", ext_ad_oe, 0);
        end
      end
      if (rsp_done) begin
        done_cnt++;
        if (exp_q.size() == 0) chk("R2/R3 unexpected done", 1, 0);
        else begin
          if (exp_q[0].rd) chk("R6 read data", rsp_rdata, exp_q[0].d);
          void'(exp_q.pop_front());
        end
      end
    end
  end

  // Driver: issues one request and checks the phase timing at the pins.
  task automatic run_xfer(input logic rd, input logic wr, input logic [15:0] a,
                          input logic [7:0] wd, input bit poke);
    bit ext;
    int ale0;
    int done0;
    ext   = xmem_en && (a >= 16'h1000) && (rd || wr);
    ale0  = ale_cnt;
    done0 = done_cnt;
    @(negedge clk);
    req_rd = rd; req_wr = wr; req_addr = a; req_wdata = wd;
    if (ext) exp_q.push_back('{rd, a, rd ? mem_val(a) : wd});
    @(negedge clk);
    req_rd = 1'b0; req_wr = 1'b0;
    if (ext) begin
      chk("R4 ale high", ext_ale, 1);
      chk("R4 bus low address", {ext_ad_oe, ext_ad_out}, {1'b1, a[7:0]});
      chk("R4 upper lines", ext_ahi, a[15:8]);
      chk("R8 ready low", ready, 0);
      if (poke) begin req_wr = 1'b1; req_addr = 16'h3000; req_wdata = 8'h77; end
      @(negedge clk);
      req_wr = 1'b0;
      chk("R5 turnaround", {ext_ale, ext_rd_n, ext_wr_n}, 3'b011);
      chk("R6/R7 turnaround drive", ext_ad_oe, !rd);
      @(negedge clk);
      chk("R6 read strobe", ext_rd_n, !rd);
      chk("R7 write strobe", ext_wr_n, rd);
      @(negedge clk);
      chk("R8 done", {rsp_done, ext_rd_n, ext_wr_n, ready}, 4'b1110);
      chk("R4 upper lines held", ext_ahi, a[15:8]);
      @(negedge clk);
      chk("R8 done ends, ready back", {rsp_done, ready}, 2'b01);
      chk("R10 single latch pulse", ale_cnt - ale0, 1);
    end else begin
      repeat (5) @(negedge clk);
      chk(xmem_en ? "R3 no latch pulse" : "R2 no latch pulse", ale_cnt - ale0, 0);
      chk(xmem_en ? "R3 no done" : "R2 no done", done_cnt - done0, 0);
      chk("R2/R3 pins idle", {ext_rd_n, ext_wr_n, ext_ad_oe}, 3'b110);
    end
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; xmem_en = 1'b0; req_rd = 1'b0; req_wr = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset pins", {ext_ale, ext_rd_n, ext_wr_n, ext_ad_oe, rsp_done}, 5'b01100);
    chk("R1 ready off while disabled", ready, 0);
    run_xfer(1'b0, 1'b1, 16'h8000, 8'h11, 1'b0);   // R2 disabled
    xmem_en = 1'b1;
    @(negedge clk);
    chk("R1 ready when enabled", ready, 1);
    run_xfer(1'b0, 1'b1, 16'h1000, 8'hA5, 1'b0);   // lowest external
    run_xfer(1'b1, 1'b0, 16'h1000, 8'h00, 1'b0);
    run_xfer(1'b0, 1'b1, 16'hFFFF, 8'h3C, 1'b0);   // highest
    run_xfer(1'b1, 1'b0, 16'hBEEF, 8'h00, 1'b0);
    run_xfer(1'b1, 1'b0, 16'h0FFF, 8'h00, 1'b0);   // R3 just below limit
    run_xfer(1'b0, 1'b1, 16'h0000, 8'h55, 1'b0);   // R3
    run_xfer(1'b1, 1'b1, 16'h4567, 8'h99, 1'b0);   // R9 both requested
    run_xfer(1'b1, 1'b0, 16'h2345, 8'h00, 1'b1);   // R10 poke while busy
    for (int i = 0; i < 8; i++)
      run_xfer(i[0], !i[0], 16'h1234 + 16'(i * 16'h1F03), 8'(i * 37), 1'b0);
    xmem_en = 1'b0;
    run_xfer(1'b1, 1'b0, 16'hC000, 8'h00, 1'b0);   // R2 read while disabled
    repeat (3) @(negedge clk);
    chk("R2 queue drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule